// File: doc/BRIEF.md
# Burst-of-Four Double-Rate Shared-Bus SRAM Model

This block is a synthesizable behavioural model of a synchronous static memory that moves data in fixed bursts of four beats, two beats per K clock period, over one shared data path. It is meant to sit on the device side of a testbench or an emulation harness. A memory controller under test drives commands and write data into it, and it answers reads the way a real part would. Everything runs on one clock at twice the K rate. An internal phase bit, brought out as `k_edge`, marks which doubled-clock edges stand for K rising edges and which stand for the complementary K# edges.

Commands (load strobe, read/write select, address) are only looked at on K edges. A write's data follows one K cycle after its command as four beats on consecutive edges, each beat with its own active-low byte mask. The beats pass through a one-entry late-write buffer before they reach the array. A read returns four beats after a fixed pipeline delay. The delay is one and a half K cycles normally and one K cycle when the `dll_bypass` input is high. The shared bus is modelled as separate in and out vectors plus an output enable, and an echo-valid flag runs alongside the read beats. A load that arrives while the previous burst still owns the interface is dropped and reported on `proto_err`. Reads see all earlier writes, including bytes still waiting in the late-write buffer.

Top module: `bst4_ddr_sram`

## Requirements
- R1: While reset is asserted `k_edge` is high. In the first cycle after release it is high, and it then inverts on every `clk2x` edge. A `clk2x` edge taken while `k_edge` is high is a K edge; the others are K# edges.
- R2: On K# edges, `ld_n`, `rw_n` and `addr` are ignored: no burst starts and `proto_err` stays low.
- R3: A write accepted on K edge c (`ld_n`=0, `rw_n`=0) captures `dq_i` on edges c+2, c+3, c+4 and c+5. Beat i is stored at the address whose upper bits equal the base address and whose low two bits are (base[1:0]+i) mod 4.
- R4: `bw_n` is active low and sampled with each beat. Bit b governs `dq_i[8b+7:8b]`. A byte whose bit is high keeps its previous content.
- R5: With `dll_bypass`=0, a read accepted on K edge c (`ld_n`=0, `rw_n`=1) drives beat i on `dq_o` with `dq_oe` high during the cycle after edge c+3+i, for i = 0..3.
- R6: With `dll_bypass`=1, beat i of such a read is driven during the cycle after edge c+2+i.
- R7: `dq_oe` is low in every cycle that carries no read beat, and `echo_vld` equals `dq_oe` in every cycle.
- R8: A load on K edge c+2 after a command accepted on K edge c is ignored and has no effect on storage or the bus. `proto_err` is then high for exactly the cycle after that edge. A load on K edge c+4 is accepted.
- R9: A read accepted on the K edge right after a write's occupancy ends returns the new write data, including the last beat that is still held in the late-write buffer.
- R10: Read beats use the same wrapped address order as R3. A write accepted after a read does not alter the data that read returns.
- R11: During reset `dq_oe`, `echo_vld` and `proto_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Internal clock at twice the K rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the environment |
| dll_bypass | input | 1 | High selects the shorter read latency; held static between resets |
| ld_n | input | 1 | Active-low load strobe, sampled on K edges |
| rw_n | input | 1 | Access type on load: high read, low write |
| addr | input | AW | Burst base address |
| bw_n | input | DW/BW | Active-low byte-write mask for the current beat |
| dq_i | input | DW | Write data beat, inbound half of the shared bus |
| dq_o | output | DW | Read data beat, outbound half of the shared bus |
| dq_oe | output | 1 | High while the model drives the shared bus |
| echo_vld | output | 1 | Echo-valid flag aligned with read beats |
| k_edge | output | 1 | High when the coming `clk2x` edge is a K edge |
| proto_err | output | 1 | One-cycle pulse after a load ignored because a burst was busy |

## Verification
On every cycle, the bound checker verifies that the phase bit alternates and that errors never follow a K# edge. It also checks that each error pulse lasts one cycle and follows a load on a K edge, that every run of bus ownership is a whole number of four-beat bursts, and that each new run begins exactly the mode's latency after a read load. Only the bench scenarios can show the data itself. These cover the wrapped beat order for every base address, per-beat byte masking, forwarding from the late-write buffer, read-before-write ordering, and that ignored or K#-phase loads leave storage untouched. The bench compares each driven beat against an array model kept in the bench, in both latency modes.

// File: rtl/bst4_pkg.sv
package bst4_pkg;
  localparam int BURST_LEN = 4;
  typedef logic [1:0] beat_t;

  function automatic beat_t beat_inc(input beat_t b);
    return b + 2'd1;
  endfunction
endpackage

// File: rtl/bst4_seq.sv
// Four-beat address sequencer: start loads the base and emits beat 0 at once,
// then beats 1..3 on the following edges, low two address bits wrapping.
module bst4_seq
  import bst4_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_base,
  output logic          beat_en,
  output logic [AW-1:0] beat_addr
);
  localparam beat_t LAST_BEAT = beat_t'(BURST_LEN - 1);

  logic          act_q, act_d;
  beat_t         cnt_q, cnt_d;
  logic [AW-1:0] base_q;
  logic [AW-1:0] base_sel;
  beat_t         beat_sel;

  always_comb begin
    base_sel = start ? start_base : base_q;
    beat_sel = start ? '0 : cnt_q;
    act_d    = start | (act_q & (cnt_q != LAST_BEAT));
    cnt_d    = start ? 2'd1 : (act_q ? beat_inc(cnt_q) : cnt_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      act_q <= act_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (start) base_q <= start_base;
  end

  assign beat_en   = start | act_q;
  assign beat_addr = {base_sel[AW-1:2], base_sel[1:0] + beat_sel};
endmodule

// File: rtl/bst4_ctrl.sv
// Phase tracking, command decode, occupancy, and the write/read start pipelines.
module bst4_ctrl
  import bst4_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byp,
  input  logic          ld_n,
  input  logic          rw_n,
  input  logic [AW-1:0] addr,
  output logic          k_edge,
  output logic          wcap_en,
  output logic [AW-1:0] wcap_addr,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic          perr
);
  // a command owns the interface for two K cycles = four doubled-clock edges
  localparam logic [1:0] OCC_LOAD = 2'(BURST_LEN - 1);

  logic          kph_q;
  logic [1:0]    occ_q, occ_d;
  logic          acc, ign;
  logic          perr_q;
  // write start pipeline: data follows the command by two edges
  logic          s1v_q, s2v_q;
  logic [AW-1:0] s1a_q, s2a_q;
  // read start pipeline: taps at two (bypass) or three edges
  logic          r1v_q, r2v_q, r3v_q;
  logic [AW-1:0] r1a_q, r2a_q, r3a_q;
  logic          rstart;
  logic [AW-1:0] rstart_a;

  always_comb begin
    acc      = kph_q & ~ld_n & (occ_q == '0);
    ign      = kph_q & ~ld_n & (occ_q != '0);
    occ_d    = acc ? OCC_LOAD : ((occ_q != '0) ? occ_q - 2'd1 : occ_q);
    rstart   = byp ? r2v_q : r3v_q;
    rstart_a = byp ? r2a_q : r3a_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kph_q  <= 1'b1;
      occ_q  <= '0;
      perr_q <= 1'b0;
      s1v_q  <= 1'b0;
      s2v_q  <= 1'b0;
      r1v_q  <= 1'b0;
      r2v_q  <= 1'b0;
      r3v_q  <= 1'b0;
    end else begin
      kph_q  <= ~kph_q;
      occ_q  <= occ_d;
      perr_q <= ign;
      s1v_q  <= acc & ~rw_n;
      s2v_q  <= s1v_q;
      r1v_q  <= acc & rw_n;
      r2v_q  <= r1v_q;
      r3v_q  <= r2v_q;
    end
  end

  always_ff @(posedge clk) begin
    if (acc) begin
      s1a_q <= addr;
      r1a_q <= addr;
    end
    s2a_q <= s1a_q;
    r2a_q <= r1a_q;
    r3a_q <= r2a_q;
  end

  bst4_seq #(.AW(AW)) u_wseq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (s2v_q),
    .start_base (s2a_q),
    .beat_en    (wcap_en),
    .beat_addr  (wcap_addr)
  );

  bst4_seq #(.AW(AW)) u_rseq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (rstart),
    .start_base (rstart_a),
    .beat_en    (rd_en),
    .beat_addr  (rd_addr)
  );

  assign k_edge = kph_q;
  assign perr   = perr_q;
endmodule

// File: rtl/bst4_wbuf.sv
// One-entry late-write buffer: holds the beat captured on the previous edge.
module bst4_wbuf #(
  parameter int AW = 6,
  parameter int DW = 16,
  parameter int NB = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_en,
  input  logic [AW-1:0] cap_addr,
  input  logic [DW-1:0] cap_data,
  input  logic [NB-1:0] cap_bw_n,
  output logic          buf_v,
  output logic [AW-1:0] buf_addr,
  output logic [DW-1:0] buf_data,
  output logic [NB-1:0] buf_mask
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) buf_v <= 1'b0;
    else        buf_v <= cap_en;
  end

  always_ff @(posedge clk) begin
    if (cap_en) begin
      buf_addr <= cap_addr;
      buf_data <= cap_data;
      buf_mask <= ~cap_bw_n;
    end
  end
endmodule

// File: rtl/bst4_store.sv
// Storage array with byte-masked commit and a read port that forwards the buffer.
module bst4_store #(
  parameter int AW = 6,
  parameter int DW = 16,
  parameter int BW = 8
) (
  input  logic             clk,
  input  logic             wb_v,
  input  logic [AW-1:0]    wb_addr,
  input  logic [DW-1:0]    wb_data,
  input  logic [DW/BW-1:0] wb_mask,
  input  logic [AW-1:0]    rd_addr,
  output logic [DW-1:0]    rd_data
);
  localparam int NB    = DW / BW;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] raw;
  logic          hit;

  always_ff @(posedge clk) begin
    if (wb_v) begin
      for (int b = 0; b < NB; b++) begin
        if (wb_mask[b]) mem[wb_addr][b*BW +: BW] <= wb_data[b*BW +: BW];
      end
    end
  end

  assign raw = mem[rd_addr];
  assign hit = wb_v & (wb_addr == rd_addr);

  for (genvar b = 0; b < NB; b++) begin : g_fwd
    assign rd_data[b*BW +: BW] = (hit & wb_mask[b]) ? wb_data[b*BW +: BW]
                                                    : raw[b*BW +: BW];
  end
endmodule

// File: rtl/bst4_ddr_sram.sv
module bst4_ddr_sram #(
  parameter int AW = 6,
  parameter int DW = 16,
  parameter int BW = 8
) (
  input  logic             clk2x,
  input  logic             rst_n,
  input  logic             dll_bypass,
  input  logic             ld_n,
  input  logic             rw_n,
  input  logic [AW-1:0]    addr,
  input  logic [DW/BW-1:0] bw_n,
  input  logic [DW-1:0]    dq_i,
  output logic [DW-1:0]    dq_o,
  output logic             dq_oe,
  output logic             echo_vld,
  output logic             k_edge,
  output logic             proto_err
);
  localparam int NB = DW / BW;

  logic          wcap_en;
  logic [AW-1:0] wcap_addr;
  logic          rd_en;
  logic [AW-1:0] rd_addr;
  logic          buf_v;
  logic [AW-1:0] buf_addr;
  logic [DW-1:0] buf_data;
  logic [NB-1:0] buf_mask;
  logic [DW-1:0] rd_data;
  logic          oe_q;
  logic [DW-1:0] dq_q;

  bst4_ctrl #(.AW(AW)) u_ctrl (
    .clk       (clk2x),
    .rst_n     (rst_n),
    .byp       (dll_bypass),
    .ld_n      (ld_n),
    .rw_n      (rw_n),
    .addr      (addr),
    .k_edge    (k_edge),
    .wcap_en   (wcap_en),
    .wcap_addr (wcap_addr),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .perr      (proto_err)
  );

  bst4_wbuf #(.AW(AW), .DW(DW), .NB(NB)) u_wbuf (
    .clk      (clk2x),
    .rst_n    (rst_n),
    .cap_en   (wcap_en),
    .cap_addr (wcap_addr),
    .cap_data (dq_i),
    .cap_bw_n (bw_n),
    .buf_v    (buf_v),
    .buf_addr (buf_addr),
    .buf_data (buf_data),
    .buf_mask (buf_mask)
  );

  bst4_store #(.AW(AW), .DW(DW), .BW(BW)) u_store (
    .clk     (clk2x),
    .wb_v    (buf_v),
    .wb_addr (buf_addr),
    .wb_data (buf_data),
    .wb_mask (buf_mask),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  always_ff @(posedge clk2x or negedge rst_n) begin
    if (!rst_n) oe_q <= 1'b0;
    else        oe_q <= rd_en;
  end

  always_ff @(posedge clk2x) begin
    if (rd_en) dq_q <= rd_data;
  end

  assign dq_o     = dq_q;
  assign dq_oe    = oe_q;
  assign echo_vld = oe_q;
endmodule

// File: rtl/bst4_ddr_sram_chk.sv
module bst4_ddr_sram_chk (
  input logic clk2x,
  input logic rst_n,
  input logic dll_bypass,
  input logic ld_n,
  input logic rw_n,
  input logic k_edge,
  input logic dq_oe,
  input logic proto_err
);
  logic       rd_load;
  logic [1:0] oe_run;

  assign rd_load = k_edge & ~ld_n & rw_n;

  always_ff @(posedge clk2x or negedge rst_n) begin
    if (!rst_n)     oe_run <= '0;
    else if (dq_oe) oe_run <= oe_run + 2'd1;
    else            oe_run <= '0;
  end

  // R1
  k_fall_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
    k_edge |=> !k_edge);
  // R1
  k_rise_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
    !k_edge |=> k_edge);
  // R2
  kbar_no_err_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
    !k_edge |=> !proto_err);
  // R8
  err_src_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
    proto_err |-> $past(k_edge & ~ld_n));
  // R8
  err_pulse_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
    proto_err |=> !proto_err);
  // R5
  burst_len_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
    $fell(dq_oe) |-> (oe_run == 2'd0));
  // R6
  rd_latency_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
    $rose(dq_oe) |-> (dll_bypass ? $past(rd_load, 3) : $past(rd_load, 4)));
endmodule

bind bst4_ddr_sram bst4_ddr_sram_chk u_chk (
  .clk2x      (clk2x),
  .rst_n      (rst_n),
  .dll_bypass (dll_bypass),
  .ld_n       (ld_n),
  .rw_n       (rw_n),
  .k_edge     (k_edge),
  .dq_oe      (dq_oe),
  .proto_err  (proto_err)
);

// File: tb/tb_bst4_ddr_sram.sv
module tb_bst4_ddr_sram;
  localparam int CLK_PERIOD = 10;
  localparam int AW    = 4;
  localparam int DW    = 16;
  localparam int BW    = 8;
  localparam int NB    = DW / BW;
  localparam int DEPTH = 1 << AW;
  localparam int MAXT  = 512;

  logic          clk2x = 1'b0;
  logic          rst_n = 1'b0;
  logic          dll_bypass = 1'b0;
  logic          ld_n = 1'b1;
  logic          rw_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [NB-1:0] bw_n = '1;
  logic [DW-1:0] dq_i = '0;
  logic [DW-1:0] dq_o;
  logic          dq_oe, echo_vld, k_edge, proto_err;

  bst4_ddr_sram #(.AW(AW), .DW(DW), .BW(BW)) dut (
    .clk2x(clk2x), .rst_n(rst_n), .dll_bypass(dll_bypass), .ld_n(ld_n),
    .rw_n(rw_n), .addr(addr), .bw_n(bw_n), .dq_i(dq_i), .dq_o(dq_o),
    .dq_oe(dq_oe), .echo_vld(echo_vld), .k_edge(k_edge), .proto_err(proto_err)
  );

  always #(CLK_PERIOD/2) clk2x = ~clk2x;

  int  n_vec = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;
  int  lat;
  int  t_end;
  string lat_tag;

  logic          ld_s   [MAXT];
  logic          rw_s   [MAXT];
  logic [AW-1:0] addr_s [MAXT];
  logic [DW-1:0] dq_s   [MAXT];
  logic [NB-1:0] bw_s   [MAXT];
  logic          exp_oe [MAXT];
  logic          exp_err[MAXT];
  logic [DW-1:0] exp_dq [MAXT];
  string         exp_tag[MAXT];
  logic [DW-1:0] ref_mem[DEPTH];

  function automatic logic [AW-1:0] baddr(input logic [AW-1:0] b, input int i);
    logic [1:0] lo;
    lo = 2'(int'(b[1:0]) + i);
    return {b[AW-1:2], lo};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at %0t: act=%0h exp=%0h", tag, $time, act, exp);
    end
  endtask

  task automatic clear_sched();
    for (int t = 0; t < MAXT; t++) begin
      ld_s[t]    = 1'b1;
      rw_s[t]    = t[0];
      addr_s[t]  = AW'(t * 7);
      dq_s[t]    = DW'((t * 40503) ^ 23130);
      bw_s[t]    = NB'(t);
      exp_oe[t]  = 1'b0;
      exp_err[t] = 1'b0;
      exp_dq[t]  = '0;
      exp_tag[t] = "R7";
    end
  endtask

  // R3 R4: expected storage after a write, per beat and per byte
  task automatic sch_wr(input int t, input logic [AW-1:0] b, input logic [DW-1:0] seed,
                        input logic [4*NB-1:0] msk);
    logic [DW-1:0] d;
    logic [AW-1:0] a;
    ld_s[t] = 1'b0; rw_s[t] = 1'b0; addr_s[t] = b;
    for (int i = 0; i < 4; i++) begin
      d = seed + DW'(i * 4951);
      a = baddr(b, i);
      dq_s[t+2+i] = d;
      bw_s[t+2+i] = msk[i*NB +: NB];
      for (int k = 0; k < NB; k++)
        if (!msk[i*NB+k]) ref_mem[a][k*BW +: BW] = d[k*BW +: BW];
    end
  endtask

  task automatic sch_rd(input int t, input logic [AW-1:0] b, input string tag);
    ld_s[t] = 1'b0; rw_s[t] = 1'b1; addr_s[t] = b;
    for (int i = 0; i < 4; i++) begin
      exp_oe[t+lat+i]  = 1'b1;
      exp_dq[t+lat+i]  = ref_mem[baddr(b, i)];
      exp_tag[t+lat+i] = tag;
    end
  endtask

  // load that must be ignored; on a K edge it raises the error flag (R8)
  task automatic sch_stray(input int t, input logic rd, input logic [AW-1:0] b);
    ld_s[t] = 1'b0; rw_s[t] = rd; addr_s[t] = b;
    if (t % 2 == 0) exp_err[t] = 1'b1;
  endtask

  task automatic build();
    int tp;
    logic [4*NB-1:0] m;
    logic [AW-1:0] wb;
    clear_sched();
    tp = 0;
    // fill every word
    for (int a = 0; a < DEPTH; a += 4) begin
      sch_wr(tp, AW'(a), DW'(4096 + a * 273), '0);
      tp += 4;
    end
    // R3 R4: every base, per-beat byte mask patterns
    for (int b = 0; b < DEPTH; b++) begin
      for (int i = 0; i < 4; i++) m[i*NB +: NB] = NB'((b + i) % 4);
      sch_wr(tp, AW'(b), DW'(12288 + b * 257), m);
      tp += 4;
    end
    // R10: read every base, with occasional idle gaps
    for (int b = 0; b < DEPTH; b++) begin
      sch_rd(tp, AW'(b), {lat_tag, " R3 R4 R10"});
      tp += (b % 3 == 0) ? 6 : 4;
    end
    // R9: read right behind a write, starting on its still-buffered last beat
    for (int k = 0; k < 4; k++) begin
      wb = AW'(k * 5);
      sch_wr(tp, wb, DW'(40960 + k * 4369), '0);
      sch_rd(tp + 4, baddr(wb, 3), "R9");
      sch_rd(tp + 8, wb, "R9");
      tp += 12;
    end
    // R10: write following a read does not disturb it
    sch_rd(tp, AW'(5), "R10");
    sch_wr(tp + 4, AW'(5), DW'(52428), '0);
    sch_rd(tp + 8, AW'(5), "R10");
    tp += 12;
    // R8: loads during occupancy are ignored
    sch_wr(tp, AW'(9), DW'(30583), '0);
    sch_stray(tp + 2, 1'b0, AW'(2));
    sch_rd(tp + 4, AW'(9), "R8");
    sch_stray(tp + 6, 1'b1, AW'(9));
    sch_rd(tp + 8, AW'(2), "R8");
    tp += 12;
    // R2: loads on K# edges have no effect
    sch_stray(tp + 1, 1'b1, AW'(3));
    sch_stray(tp + 3, 1'b0, AW'(3));
    sch_rd(tp + 8, AW'(3), "R2");
    tp += 12;
    t_end = tp + 8;
  endtask

  task automatic reset_dut(input logic byp);
    rst_n = 1'b0; ld_n = 1'b1; rw_n = 1'b1; addr = '0; bw_n = '1; dq_i = '0;
    dll_bypass = byp;
    repeat (4) @(negedge clk2x);
    chk(dq_oe == 1'b0,     "R11 dq_oe",     32'(dq_oe),     0);
    chk(echo_vld == 1'b0,  "R11 echo_vld",  32'(echo_vld),  0);
    chk(proto_err == 1'b0, "R11 proto_err", 32'(proto_err), 0);
    chk(k_edge == 1'b1,    "R1 reset",      32'(k_edge),    1);
    rst_n = 1'b1;
  endtask

  task automatic compare(input int u);
    chk(dq_oe == exp_oe[u], exp_oe[u] ? exp_tag[u] : "R7", 32'(dq_oe), 32'(exp_oe[u]));
    chk(echo_vld == exp_oe[u], "R7 echo", 32'(echo_vld), 32'(exp_oe[u]));
    if (exp_oe[u]) chk(dq_o == exp_dq[u], exp_tag[u], 32'(dq_o), 32'(exp_dq[u]));
    chk(proto_err == exp_err[u], (u % 2) ? "R2" : "R8", 32'(proto_err), 32'(exp_err[u]));
  endtask

  task automatic run_sched();
    for (int t = 0; t <= t_end; t++) begin
      if (t > 0) begin
        @(negedge clk2x);
        compare(t - 1);
      end
      chk(k_edge == !t[0], "R1", 32'(k_edge), 32'(!t[0]));
      ld_n = ld_s[t]; rw_n = rw_s[t]; addr = addr_s[t];
      dq_i = dq_s[t]; bw_n = bw_s[t];
    end
  endtask

  initial begin
    for (int mode = 0; mode < 2; mode++) begin
      lat     = (mode == 1) ? 2 : 3;
      lat_tag = (mode == 1) ? "R6" : "R5";
      reset_dut(mode[0]);
      build();
      run_sched();
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk2x);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog: act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule